// File: doc/BRIEF.md
# Bidirectional FIFO port access controller

This block sits behind one 36-bit bidirectional port of a buffer that holds two FIFOs and two mailbox registers. On every rising clock edge it samples four control pins. These are an active-low chip select, a direction pin (high means write, low means read), an access enable and a mailbox select. From them it forms four exclusive strobes: write into the inbound FIFO, read from the outbound FIFO, write into the inbound mailbox, and read from the outbound mailbox.

FIFO strobes are qualified with the status that the FIFO presents: space for a write, data for a read. A request that meets a blocked status is dropped, and no strobe is sent. Mailbox strobes carry no status gating. The downstream mailbox logic uses the read strobe to return its flag to the inactive level. The strobes and the captured write word are registered, so the storage consumes them on the following edge.

The bus is modelled as separate in, out and output-enable signals. The output enable is purely combinational and follows chip select and direction, whatever the enable pin or the clock is doing. The outgoing word comes from whichever source, FIFO or mailbox, was read most recently.

Top module: `xport_access_ctrl`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n`=0 and `wr_rd`=0. It follows those two pins combinationally, with no clock edge, whatever the value of `en`.
- R2: `bus_out` equals `m2_rdata` after the most recent qualified read was a mailbox read. It equals `f2_rdata` after the most recent qualified read was a FIFO read. It also equals `f2_rdata` from reset until the first read.
- R3: An edge with `cs_n`=0, `wr_rd`=1, `en`=1, `mbx_sel`=0 and `f1_space`=1 raises `f1_wr` for the one cycle after that edge. In that cycle `wr_data` holds the `bus_in` value sampled at the edge.
- R4: An edge with `cs_n`=0, `wr_rd`=0, `en`=1, `mbx_sel`=0 and `f2_avail`=1 raises `f2_rd` for the one cycle after that edge.
- R5: An edge with `cs_n`=0, `wr_rd`=1, `en`=1 and `mbx_sel`=1 raises `m1_wr` for the one cycle after that edge, whatever the value of `f1_space`. In that cycle `wr_data` holds the sampled `bus_in`.
- R6: An edge with `cs_n`=0, `wr_rd`=0, `en`=1 and `mbx_sel`=1 raises `m2_rd` for the one cycle after that edge, whatever the value of `f2_avail`.
- R7: An edge with `en`=0 or `cs_n`=1 raises no strobe, whatever the values of `wr_rd` and `mbx_sel`.
- R8: A FIFO write with `f1_space`=0, or a FIFO read with `f2_avail`=0, raises no strobe at all. Such a blocked read also leaves the `bus_out` source unchanged.
- R9: At most one of `f1_wr`, `f2_rd`, `m1_wr`, `m2_rd` is high in any cycle.
- R10: While `rst_n`=0, all four strobes are 0 and the `bus_out` source is the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_rd | input | 1 | Direction: 1 write, 0 read |
| en | input | 1 | Access enable |
| mbx_sel | input | 1 | 1 selects a mailbox, 0 selects a FIFO |
| f1_space | input | 1 | Inbound FIFO can take a word |
| f2_avail | input | 1 | Outbound FIFO holds a word |
| bus_in | input | DATA_W | Bus input half |
| f2_rdata | input | DATA_W | Outbound FIFO output word |
| m2_rdata | input | DATA_W | Outbound mailbox word |
| bus_out | output | DATA_W | Bus output half |
| bus_oe | output | 1 | Bus output enable |
| f1_wr | output | 1 | Inbound FIFO write strobe |
| f2_rd | output | 1 | Outbound FIFO read strobe |
| m1_wr | output | 1 | Inbound mailbox write strobe |
| m2_rd | output | 1 | Outbound mailbox read strobe |
| wr_data | output | DATA_W | Word captured for a write |

## Verification
The bench builds the block with DATA_W=36 and REG_STROBES=1. This gives the full-width word capture and the one-cycle registered strobe timing, and every strobe is observed in the cycle after its sampling edge. A directed walk covers all 64 combinations of the four control pins and the two status bits. This brings every row of the enable table within reach, blocked rows included. Random vectors then stress the switching of the mailbox and FIFO output source across back-to-back reads.

// File: rtl/xport_pkg.sv
package xport_pkg;

  typedef struct packed {
    logic f1_wr;
    logic f2_rd;
    logic m1_wr;
    logic m2_rd;
  } xport_ops_t;

  localparam xport_ops_t XPORT_IDLE = '{default: 1'b0};

  // Raw request decode from the control pins, before status gating.
  function automatic xport_ops_t xport_request(input logic cs_n, input logic wr_rd,
                                               input logic en, input logic mbx_sel);
    xport_ops_t r;
    logic       act;
    act     = !cs_n && en;
    r.f1_wr = act &&  wr_rd && !mbx_sel;
    r.f2_rd = act && !wr_rd && !mbx_sel;
    r.m1_wr = act &&  wr_rd &&  mbx_sel;
    r.m2_rd = act && !wr_rd &&  mbx_sel;
    return r;
  endfunction

  // Bus drive condition: purely a function of select and direction.
  function automatic logic xport_drive(input logic cs_n, input logic wr_rd);
    return !cs_n && !wr_rd;
  endfunction

endpackage

// File: rtl/xport_decode.sv
module xport_decode
  import xport_pkg::*;
(
  input  logic       cs_n,
  input  logic       wr_rd,
  input  logic       en,
  input  logic       mbx_sel,
  output xport_ops_t req
);
  always_comb req = xport_request(cs_n, wr_rd, en, mbx_sel);
endmodule

// File: rtl/xport_gate.sv
module xport_gate
  import xport_pkg::*;
(
  input  xport_ops_t req,
  input  logic       f1_space,
  input  logic       f2_avail,
  output xport_ops_t qual
);
  always_comb begin
    qual       = req;
    qual.f1_wr = req.f1_wr && f1_space;
    qual.f2_rd = req.f2_rd && f2_avail;
  end
endmodule

// File: rtl/xport_stage.sv
module xport_stage
  import xport_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter bit REG_STROBES = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xport_ops_t        qual,
  input  logic [DATA_W-1:0] din,
  output xport_ops_t        ops,
  output logic [DATA_W-1:0] dout
);
  generate
    if (REG_STROBES) begin : g_reg
      xport_ops_t        ops_q;
      logic [DATA_W-1:0] dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ops_q <= XPORT_IDLE;
          dat_q <= '0;
        end else begin
          ops_q <= qual;
          if (qual.f1_wr || qual.m1_wr) dat_q <= din;
        end
      end
      assign ops  = ops_q;
      assign dout = dat_q;
    end else begin : g_comb
      assign ops  = rst_n ? qual : XPORT_IDLE;
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/xport_bus.sv
module xport_bus
  import xport_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_rd,
  input  xport_ops_t        qual,
  input  logic [DATA_W-1:0] f2_rdata,
  input  logic [DATA_W-1:0] m2_rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic src_mbx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           src_mbx <= 1'b0;
    else if (qual.m2_rd)  src_mbx <= 1'b1;
    else if (qual.f2_rd)  src_mbx <= 1'b0;
  end

  assign bus_out = src_mbx ? m2_rdata : f2_rdata;
  assign bus_oe  = xport_drive(cs_n, wr_rd);
endmodule

// File: rtl/xport_access_ctrl.sv
module xport_access_ctrl
  import xport_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter bit REG_STROBES = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_rd,
  input  logic              en,
  input  logic              mbx_sel,
  input  logic              f1_space,
  input  logic              f2_avail,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] f2_rdata,
  input  logic [DATA_W-1:0] m2_rdata,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              f1_wr,
  output logic              f2_rd,
  output logic              m1_wr,
  output logic              m2_rd,
  output logic [DATA_W-1:0] wr_data
);
  xport_ops_t req, qual, ops;

  // Named internal events for the checker
  logic [3:0] q_ev;

  xport_decode u_dec (.cs_n(cs_n), .wr_rd(wr_rd), .en(en), .mbx_sel(mbx_sel), .req(req));

  xport_gate u_gate (.req(req), .f1_space(f1_space), .f2_avail(f2_avail), .qual(qual));

  xport_stage #(.DATA_W(DATA_W), .REG_STROBES(REG_STROBES)) u_stage (
    .clk(clk), .rst_n(rst_n), .qual(qual), .din(bus_in), .ops(ops), .dout(wr_data)
  );

  xport_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .qual(qual),
    .f2_rdata(f2_rdata), .m2_rdata(m2_rdata), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign q_ev  = {qual.f1_wr, qual.f2_rd, qual.m1_wr, qual.m2_rd};
  assign f1_wr = ops.f1_wr;
  assign f2_rd = ops.f2_rd;
  assign m1_wr = ops.m1_wr;
  assign m2_rd = ops.m2_rd;
endmodule

// File: rtl/xport_access_chk.sv
module xport_access_chk #(
  parameter int DATA_W      = 36,
  parameter bit REG_STROBES = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_rd,
  input logic              en,
  input logic              f1_space,
  input logic              f2_avail,
  input logic [DATA_W-1:0] m2_rdata,
  input logic [DATA_W-1:0] f2_rdata,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe,
  input logic              f1_wr,
  input logic              f2_rd,
  input logic              m1_wr,
  input logic              m2_rd,
  input logic [3:0]        q_ev
);
  // R1
  oe_off_chk: assert property (@(posedge clk) (cs_n || wr_rd) |-> !bus_oe);
  // R1
  oe_on_chk: assert property (@(posedge clk) (!cs_n && !wr_rd) |-> bus_oe);
  // R7
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n) (!en || cs_n) |-> (q_ev == 4'b0000));
  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n) !f1_space |-> !q_ev[3]);
  // R8
  empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n) !f2_avail |-> !q_ev[2]);
  // R9
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({f1_wr, f2_rd, m1_wr, m2_rd}));
  // R2
  mbx_source_chk: assert property (@(posedge clk) disable iff (!rst_n) q_ev[0] |=> (bus_out == m2_rdata));
  // R2
  fifo_source_chk: assert property (@(posedge clk) disable iff (!rst_n) q_ev[2] |=> (bus_out == f2_rdata));

  generate
    if (REG_STROBES) begin : g_regchk
      // R3
      f1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) q_ev[3] |=> f1_wr);
      // R6
      m2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) q_ev[0] |=> m2_rd);
      // R7
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (q_ev == 4'b0000) |=> !(f1_wr || f2_rd || m1_wr || m2_rd));
    end
  endgenerate
endmodule

bind xport_access_ctrl xport_access_chk #(.DATA_W(DATA_W), .REG_STROBES(REG_STROBES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .en(en),
  .f1_space(f1_space), .f2_avail(f2_avail), .m2_rdata(m2_rdata), .f2_rdata(f2_rdata),
  .bus_out(bus_out), .bus_oe(bus_oe), .f1_wr(f1_wr), .f2_rd(f2_rd),
  .m1_wr(m1_wr), .m2_rd(m2_rd), .q_ev(q_ev)
);

// File: tb/xport_access_ctrl_test.sv
`timescale 1ns/1ps
module xport_access_ctrl_test;
  localparam int W = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_rd = 1'b0, en = 1'b0, mbx_sel = 1'b0, f1_space = 1'b0, f2_avail = 1'b0;
  logic [W-1:0] bus_in = '0, f2_rdata = '0, m2_rdata = '0;
  logic [W-1:0] bus_out, wr_data;
  logic bus_oe, f1_wr, f2_rd, m1_wr, m2_rd;

  int checks = 0;
  int fails  = 0;
  bit exp_mbx = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xport_access_ctrl #(.DATA_W(W), .REG_STROBES(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .en(en), .mbx_sel(mbx_sel),
    .f1_space(f1_space), .f2_avail(f2_avail), .bus_in(bus_in), .f2_rdata(f2_rdata),
    .m2_rdata(m2_rdata), .bus_out(bus_out), .bus_oe(bus_oe), .f1_wr(f1_wr), .f2_rd(f2_rd),
    .m1_wr(m1_wr), .m2_rd(m2_rd), .wr_data(wr_data)
  );

  // Expected strobes {f1_wr, f2_rd, m1_wr, m2_rd} from the enable table
  function automatic logic [3:0] exp_ops(logic c, logic w, logic e, logic m, logic s, logic a);
    logic go;
    go = (c == 1'b0) && (e == 1'b1);
    if (!go)      return 4'b0000;
    if (w && m)   return 4'b0010;
    if (!w && m)  return 4'b0001;
    if (w)        return s ? 4'b1000 : 4'b0000;
    return a ? 4'b0100 : 4'b0000;
  endfunction

  function automatic string op_tag(logic c, logic w, logic e, logic m, logic s, logic a);
    if (c || !e)        return "R7";
    if (w && m)         return "R5";
    if (!w && m)        return "R6";
    if (w && !s)        return "R8";
    if (!w && !a)       return "R8";
    return w ? "R3" : "R4";
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic c, logic w, logic e, logic m, logic s, logic a);
    logic [3:0] eo;
    logic [W-1:0] din;
    @(negedge clk);
    cs_n = c; wr_rd = w; en = e; mbx_sel = m; f1_space = s; f2_avail = a;
    din = {$urandom, $urandom};
    bus_in = din;
    f2_rdata = {$urandom, $urandom};
    m2_rdata = {$urandom, $urandom};
    #2;
    check(bus_oe == (!c && !w), "R1", {35'd0, bus_oe}, {35'd0, (!c && !w)});
    check(bus_out == (exp_mbx ? m2_rdata : f2_rdata), "R2", bus_out, exp_mbx ? m2_rdata : f2_rdata);
    eo = exp_ops(c, w, e, m, s, a);
    @(posedge clk);
    #1;
    check({f1_wr, f2_rd, m1_wr, m2_rd} == eo, op_tag(c, w, e, m, s, a),
          {32'd0, f1_wr, f2_rd, m1_wr, m2_rd}, {32'd0, eo});
    check($countones({f1_wr, f2_rd, m1_wr, m2_rd}) <= 1, "R9",
          {32'd0, f1_wr, f2_rd, m1_wr, m2_rd}, {32'd0, eo});
    if (eo[3] || eo[1]) check(wr_data == din, eo[3] ? "R3" : "R5", wr_data, din);
    if (eo[0]) exp_mbx = 1'b1;
    else if (eo[2]) exp_mbx = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R10: active-looking pins during reset must not strobe
    cs_n = 1'b0; wr_rd = 1'b1; en = 1'b1; f1_space = 1'b1; f2_avail = 1'b1;
    f2_rdata = 36'h0_1234_5678; m2_rdata = 36'h9_8765_4321;
    repeat (3) @(posedge clk);
    #1;
    check({f1_wr, f2_rd, m1_wr, m2_rd} == 4'b0000, "R10", {32'd0, f1_wr, f2_rd, m1_wr, m2_rd}, '0);
    check(bus_out == f2_rdata, "R10", bus_out, f2_rdata);
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    // Directed walk: every row of the enable table with both status bits
    for (int i = 0; i < 64; i++)
      apply(i[5], i[4], i[3], i[2], i[1], i[0]);
    // Corner: mailbox read then blocked FIFO read keeps mailbox source (R8, R2)
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // Corner: back-to-back FIFO read after mailbox read switches source (R2)
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    // Random phase, biased toward active accesses
    for (int k = 0; k < 400; k++) begin
      logic [5:0] r;
      r = 6'($urandom);
      apply(($urandom % 4) == 0, r[4], ($urandom % 4) != 0, r[2], r[1], r[0]);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule